// File: doc/BRIEF.md
# Instruction Doorbell and In-Flight Tracker

This block keeps the books for one instruction queue. Software announces new work by writing a word count to a doorbell register. The block adds that count to a 20-bit pending-word total. Each instruction is eight 64-bit words. Whenever the queue is enabled, at least one whole instruction is pending, and the in-flight counter has room, the block raises a fetch request. A grant on that request takes eight words off the pending total and adds one to the in-flight count. The execution side sends a one-cycle completion pulse for each finished instruction, and that pulse lowers the in-flight count.

A doorbell write that carries the total past 2^20 sets a sticky overflow flag. Software clears the flag by writing a one to it. The interrupt output is that flag gated by an enable bit, which has its own set and clear addresses. Software can return the pending total to zero by writing 2^20 minus the current value, which relies on modular wrap. This write also sets the overflow flag, so software clears the interrupt enable first and then clears the flag. To quiesce the queue, software clears the queue enable and polls the in-flight count until it reads zero.

Registers are reached through a single-cycle write strobe and a combinational read port, addressed by a 3-bit word address.

Top module: `instr_doorbell_tracker`

## Requirements
- R1: After synchronous reset, the following are all zero: the pending count, the in-flight count, the overflow flag, the interrupt enable, the queue enable, `fetchReq` and `irqOut`.
- R2: A write to address 0 adds `regWrData` to the pending count modulo 2^20, taking effect on the next clock. Reading address 0 returns the pending count.
- R3: When the sum of the pending count and the doorbell value reaches 2^20 or more, the overflow flag is set on the next clock. `irqOut` is high exactly when the flag and the interrupt enable are both 1.
- R4: The overflow flag reads as bit 0 of address 3. It is cleared only by a write to address 3 with bit 0 = 1. A write there with bit 0 = 0 leaves the flag unchanged.
- R5: A write with bit 0 = 1 to address 4 sets the interrupt enable. A write with bit 0 = 1 to address 5 clears it. Bit 0 of both addresses reads the enable.
- R6: `fetchReq` is high exactly when the queue is enabled, the pending count is at least 8, and the in-flight count is below 255.
- R7: A cycle with `fetchReq` and `fetchGnt` both high lowers the pending count by 8 and raises the in-flight count by 1.
- R8: A `doneIn` pulse lowers the in-flight count by 1. A pulse at zero is ignored. A grant and a completion in the same cycle leave the count unchanged.
- R9: The queue enable is bit 0 of address 2'd1 (address 1), and it is readable there. While it is 0, no fetch is requested, and completions still drain the in-flight count to zero.
- R10: A doorbell value that is not a multiple of 8 is added as-is. A fetch waits until at least 8 words are pending.
- R11: Writing 2^20 minus the pending count returns the count to zero and sets the flag. With the interrupt enable cleared beforehand, `irqOut` stays low.
- R12: Address 2 reads the 8-bit in-flight count in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address (write and read) |
| regWrData | input | 20 | Register write data |
| regRdData | output | 20 | Register read data for `regAddr` (combinational) |
| fetchReq | output | 1 | Request to fetch one whole instruction |
| fetchGnt | input | 1 | Fetch grant; takes effect only with `fetchReq` |
| doneIn | input | 1 | One-cycle pulse per completed instruction |
| irqOut | output | 1 | Doorbell overflow interrupt |

## Verification
On every cycle, the assertions check the following cycle-to-cycle relations:
- the modular doorbell addition and the overflow flag it sets;
- that the flag holds until a write-one clear;
- the effect of a grant and of a completion on the in-flight count, including the pulse at zero;
- that a disabled queue never requests a fetch.

Some behaviours need a whole sequence, and only the bench's scenarios can show them:
- the wrap-clear sequence with the interrupt enable dropped first;
- filling the in-flight counter to 255 and seeing the request stop;
- draining it to zero with the queue disabled;
- the end-to-end agreement of every readback with the reference model under random grant, completion and doorbell traffic.

// File: rtl/doorbell_trk_pkg.sv
package doorbell_trk_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_DBELL    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_QCTL     = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_INFL     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ISTAT    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IENA_SET = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_IENA_CLR = 3'd5;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic dbAdd;
    logic fetchTake;
    logic doneTake;
    logic enaWr;
    logic flagClr;
    logic ieSet;
    logic ieClr;
  } trkStrobe_t;
endpackage

// File: rtl/doorbell_trk_ctrl.sv
module doorbell_trk_ctrl
  import doorbell_trk_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrBit0,
  input  logic              fetchGnt,
  input  logic              doneIn,
  input  logic              queueEna,
  input  logic              enoughWords,
  input  logic              inflightFull,
  input  logic              inflightZero,
  output logic              fetchReq,
  output trkStrobe_t        strobe
);
  always_comb begin
    fetchReq         = queueEna & enoughWords & ~inflightFull;
    strobe.dbAdd     = regWrEn && (regAddr == ADR_DBELL);
    strobe.enaWr     = regWrEn && (regAddr == ADR_QCTL);
    strobe.flagClr   = regWrEn && (regAddr == ADR_ISTAT) && wrBit0;
    strobe.ieSet     = regWrEn && (regAddr == ADR_IENA_SET) && wrBit0;
    strobe.ieClr     = regWrEn && (regAddr == ADR_IENA_CLR) && wrBit0;
    strobe.fetchTake = fetchReq & fetchGnt;
    strobe.doneTake  = doneIn & ~inflightZero;
  end
endmodule

// File: rtl/doorbell_trk_datapath.sv
module doorbell_trk_datapath
  import doorbell_trk_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int IF_W  = 8,
  parameter int WPI   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  trkStrobe_t        strobe,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  regRdData,
  output logic [CNT_W-1:0]  pendingCnt,
  output logic [IF_W-1:0]   inflightCnt,
  output logic              ovfFlag,
  output logic              intEna,
  output logic              queueEna,
  output logic              enoughWords,
  output logic              inflightFull,
  output logic              inflightZero,
  output logic              irqOut
);
  localparam logic [CNT_W-1:0] STEP   = CNT_W'(WPI);
  localparam logic [IF_W-1:0]  IF_MAX = '1;

  logic [CNT_W-1:0] addVal;
  logic [CNT_W:0]   sumWide;
  logic [CNT_W-1:0] cntNext;
  logic             carry;

  always_comb begin
    addVal  = strobe.dbAdd ? wrData : '0;
    sumWide = {1'b0, pendingCnt} + {1'b0, addVal};
    carry   = sumWide[CNT_W];
    cntNext = sumWide[CNT_W-1:0] - (strobe.fetchTake ? STEP : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingCnt  <= '0;
      inflightCnt <= '0;
      ovfFlag     <= 1'b0;
      intEna      <= 1'b0;
      queueEna    <= 1'b0;
    end else begin
      pendingCnt <= cntNext;
      case ({strobe.fetchTake, strobe.doneTake})
        2'b10:   inflightCnt <= inflightCnt + 1'b1;
        2'b01:   inflightCnt <= inflightCnt - 1'b1;
        default: inflightCnt <= inflightCnt;
      endcase
      // A new overflow has priority over a software clear
      if (carry)               ovfFlag <= 1'b1;
      else if (strobe.flagClr) ovfFlag <= 1'b0;
      if (strobe.ieSet)      intEna <= 1'b1;
      else if (strobe.ieClr) intEna <= 1'b0;
      if (strobe.enaWr) queueEna <= wrData[0];
    end
  end

  always_comb begin
    enoughWords  = pendingCnt >= STEP;
    inflightFull = inflightCnt == IF_MAX;
    inflightZero = inflightCnt == '0;
    irqOut       = ovfFlag & intEna;
    case (rdAddr)
      ADR_DBELL:    regRdData = pendingCnt;
      ADR_QCTL:     regRdData = {{(CNT_W-1){1'b0}}, queueEna};
      ADR_INFL:     regRdData = {{(CNT_W-IF_W){1'b0}}, inflightCnt};
      ADR_ISTAT:    regRdData = {{(CNT_W-1){1'b0}}, ovfFlag};
      ADR_IENA_SET,
      ADR_IENA_CLR: regRdData = {{(CNT_W-1){1'b0}}, intEna};
      default:      regRdData = '0;
    endcase
  end
endmodule

// File: rtl/instr_doorbell_tracker.sv
module instr_doorbell_tracker
  import doorbell_trk_pkg::*;
#(
  parameter int CNT_W           = 20,
  parameter int IF_W            = 8,
  parameter int WORDS_PER_INSTR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output logic              fetchReq,
  input  logic              fetchGnt,
  input  logic              doneIn,
  output logic              irqOut
);
  trkStrobe_t       strobe;
  logic [CNT_W-1:0] pendingCnt;
  logic [IF_W-1:0]  inflightCnt;
  logic             ovfFlag;
  logic             intEna;
  logic             queueEna;
  logic             enoughWords;
  logic             inflightFull;
  logic             inflightZero;

  doorbell_trk_ctrl u_ctrl (
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .wrBit0       (regWrData[0]),
    .fetchGnt     (fetchGnt),
    .doneIn       (doneIn),
    .queueEna     (queueEna),
    .enoughWords  (enoughWords),
    .inflightFull (inflightFull),
    .inflightZero (inflightZero),
    .fetchReq     (fetchReq),
    .strobe       (strobe)
  );

  doorbell_trk_datapath #(
    .CNT_W (CNT_W),
    .IF_W  (IF_W),
    .WPI   (WORDS_PER_INSTR)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .wrData       (regWrData),
    .rdAddr       (regAddr),
    .regRdData    (regRdData),
    .pendingCnt   (pendingCnt),
    .inflightCnt  (inflightCnt),
    .ovfFlag      (ovfFlag),
    .intEna       (intEna),
    .queueEna     (queueEna),
    .enoughWords  (enoughWords),
    .inflightFull (inflightFull),
    .inflightZero (inflightZero),
    .irqOut       (irqOut)
  );
endmodule

// File: rtl/doorbell_trk_checker.sv
module doorbell_trk_checker
  import doorbell_trk_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int IF_W  = 8,
  parameter int WPI   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWrData,
  input logic              fetchReq,
  input logic              fetchGnt,
  input logic              doneIn,
  input logic [CNT_W-1:0]  pendingCnt,
  input logic [IF_W-1:0]   inflightCnt,
  input logic              ovfFlag,
  input logic              intEna,
  input logic              queueEna
);
  logic [CNT_W:0]   wideSum;
  logic [CNT_W-1:0] sumLow;
  logic             dbWr;
  logic             took;
  logic [IF_W-1:0]  infPlus;
  logic [IF_W-1:0]  infMinus;

  always_comb begin
    wideSum  = {1'b0, pendingCnt} + {1'b0, regWrData};
    sumLow   = wideSum[CNT_W-1:0];
    dbWr     = regWrEn && (regAddr == ADR_DBELL);
    took     = fetchReq && fetchGnt;
    infPlus  = inflightCnt + 1'b1;
    infMinus = inflightCnt - 1'b1;
  end

  assert_db_add_R2: assert property (@(posedge clk) disable iff (rst)
    dbWr && !took |=> pendingCnt == $past(sumLow));

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    dbWr && wideSum[CNT_W] |=> ovfFlag);

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ovfFlag && !(regWrEn && regAddr == ADR_ISTAT && regWrData[0]) |=> ovfFlag);

  assert_ie_set_R5: assert property (@(posedge clk) disable iff (rst)
    regWrEn && regAddr == ADR_IENA_SET && regWrData[0] |=> intEna);

  assert_fetch_room_R6: assert property (@(posedge clk) disable iff (rst)
    fetchReq |-> (pendingCnt >= CNT_W'(WPI)) && (inflightCnt != '1));

  assert_take_R7: assert property (@(posedge clk) disable iff (rst)
    took && !doneIn |=> inflightCnt == $past(infPlus));

  assert_done_R8: assert property (@(posedge clk) disable iff (rst)
    doneIn && !took && inflightCnt != '0 |=> inflightCnt == $past(infMinus));

  assert_done_zero_R8: assert property (@(posedge clk) disable iff (rst)
    doneIn && !took && inflightCnt == '0 |=> inflightCnt == '0);

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !queueEna |-> !fetchReq);
endmodule

bind instr_doorbell_tracker doorbell_trk_checker #(
  .CNT_W (CNT_W),
  .IF_W  (IF_W),
  .WPI   (WORDS_PER_INSTR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .fetchReq    (fetchReq),
  .fetchGnt    (fetchGnt),
  .doneIn      (doneIn),
  .pendingCnt  (pendingCnt),
  .inflightCnt (inflightCnt),
  .ovfFlag     (ovfFlag),
  .intEna      (intEna),
  .queueEna    (queueEna)
);

// File: tb/test_instr_doorbell_tracker.sv
`timescale 1ns/1ps
module test_instr_doorbell_tracker;
  localparam int CNT_W   = 20;
  localparam int IF_W    = 8;
  localparam int WPI     = 8;
  localparam int CNT_MOD = 1 << CNT_W;
  localparam int IF_MAXV = (1 << IF_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             regWrEn = 1'b0;
  logic [2:0]       regAddr = 3'd0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [CNT_W-1:0] regRdData;
  logic             fetchReq;
  logic             fetchGnt = 1'b0;
  logic             doneIn = 1'b0;
  logic             irqOut;

  instr_doorbell_tracker i_instr_doorbell_tracker (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchReq(fetchReq),
    .fetchGnt(fetchGnt), .doneIn(doneIn), .irqOut(irqOut)
  );

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // Behavioural reference model
  int mCount = 0;
  int mInfl  = 0;
  bit mFlag  = 0;
  bit mIe    = 0;
  bit mEna   = 0;
  int mSum;
  bit mTake;
  bit mDn;

  function automatic bit mReq();
    return mEna && (mCount >= WPI) && (mInfl < IF_MAXV);
  endfunction

  function automatic int mRead(input int a);
    case (a)
      0: return mCount;
      1: return int'(mEna);
      2: return mInfl;
      3: return int'(mFlag);
      4, 5: return int'(mIe);
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input int a);
    case (a)
      0: return "R2 pending readback";
      1: return "R9 queue enable readback";
      2: return "R12 in-flight readback";
      3: return "R4 flag readback";
      4, 5: return "R5 enable readback";
      default: return "R2 unused address";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCount = 0; mInfl = 0; mFlag = 0; mIe = 0; mEna = 0;
    end else begin
      mTake = mReq() && fetchGnt;
      mDn   = doneIn && (mInfl > 0);
      mSum  = mCount + ((regWrEn && regAddr == 3'd0) ? int'(regWrData) : 0);
      if (mSum >= CNT_MOD) mFlag = 1;
      else if (regWrEn && regAddr == 3'd3 && regWrData[0]) mFlag = 0;
      mCount = (mSum - (mTake ? WPI : 0)) % CNT_MOD;
      mInfl  = mInfl + int'(mTake) - int'(mDn);
      if (regWrEn && regAddr == 3'd1) mEna = regWrData[0];
      if (regWrEn && regAddr == 3'd4 && regWrData[0]) mIe = 1;
      if (regWrEn && regAddr == 3'd5 && regWrData[0]) mIe = 0;
    end
  end

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checkVal("R6 fetchReq vs model", int'(fetchReq), int'(mReq()));
      checkVal("R3 irqOut vs model", int'(irqOut), int'(mFlag && mIe));
      checkVal(tagFor(int'(regAddr)), int'(regRdData), mRead(int'(regAddr)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      report();
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = CNT_W'(d);
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); #1;
    regAddr = 3'(a);
    #1 checkVal(tag, int'(regRdData), exp);
  endtask

  task automatic pulse(input bit g, input bit d);
    @(negedge clk); #1;
    fetchGnt = g; doneIn = d;
    @(negedge clk); #1;
    fetchGnt = 1'b0; doneIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    checkVal("R1 fetchReq", int'(fetchReq), 0);
    checkVal("R1 irqOut", int'(irqOut), 0);
    rd(0, 0, "R1 pending");
    rd(1, 0, "R1 queue enable");
    rd(2, 0, "R1 in-flight");
    rd(3, 0, "R1 flag");
    rd(4, 0, "R1 interrupt enable");

    // R10 partial doorbell, R6 request, R7 grant
    wr(1, 1);
    wr(0, 5);
    checkVal("R10 no fetch below 8 words", int'(fetchReq), 0);
    rd(0, 5, "R10 partial count kept");
    wr(0, 3);
    checkVal("R6 request at 8 words", int'(fetchReq), 1);
    pulse(1, 0);
    rd(0, 0, "R7 count minus 8");
    rd(2, 1, "R7 in-flight plus 1");
    checkVal("R6 request drops", int'(fetchReq), 0);

    // R8 completion cases
    wr(0, 16);
    pulse(1, 1);
    rd(2, 1, "R8 grant and done together");
    rd(0, 8, "R7 count after grant");
    pulse(0, 1);
    rd(2, 0, "R8 done decrements");
    pulse(0, 1);
    rd(2, 0, "R8 done at zero ignored");
    wr(1, 0);
    checkVal("R9 disabled stops request", int'(fetchReq), 0);

    // R3 overflow, R4 write-one-to-clear, R5 enable
    wr(4, 1);
    rd(4, 1, "R5 set via set address");
    wr(0, CNT_MOD - 4);
    checkVal("R3 irq on overflow", int'(irqOut), 1);
    rd(3, 1, "R3 flag set");
    rd(0, 4, "R2 modular sum");
    wr(3, 0);
    rd(3, 1, "R4 write of zero ignored");
    wr(3, 1);
    rd(3, 0, "R4 write one clears");
    checkVal("R4 irq low after clear", int'(irqOut), 0);

    // R11 wrap clear with enable dropped first
    wr(5, 1);
    rd(4, 0, "R5 cleared via clear address");
    rd(5, 0, "R5 clear address readback");
    wr(0, CNT_MOD - 4);
    rd(0, 0, "R11 count wrapped to zero");
    rd(3, 1, "R11 flag raised by wrap");
    checkVal("R11 irq stays low", int'(irqOut), 0);
    wr(3, 1);
    wr(4, 1);
    rd(5, 1, "R5 enable set again");

    // Random traffic compared with the model every cycle
    wr(1, 1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      fetchGnt = 1'($urandom % 2);
      doneIn = (mInfl > 0) && ($urandom % 3 == 0);
      if ($urandom % 8 == 0) begin
        regWrEn = 1'b1; regAddr = 3'd0;
        regWrData = CNT_W'(WPI * ($urandom % 4));
      end else begin
        regWrEn = 1'b0; regAddr = 3'($urandom % 6);
      end
    end
    @(negedge clk); #1;
    regWrEn = 1'b0; fetchGnt = 1'b0; doneIn = 1'b0;
    wr(1, 0);
    for (int i = 0; i < 300 && mInfl > 0; i++) pulse(0, 1);
    rd(2, 0, "R9 drained after traffic");
    wr(5, 1);
    if (mCount != 0) wr(0, CNT_MOD - mCount);
    rd(0, 0, "R11 wrap clear after traffic");
    checkVal("R11 irq low after wrap", int'(irqOut), 0);
    wr(3, 1);

    // R6 in-flight limit, R12 readback, R9 drain while disabled
    wr(1, 1);
    wr(0, 2400);
    @(negedge clk); #1 fetchGnt = 1'b1;
    repeat (300) @(negedge clk);
    #1 fetchGnt = 1'b0;
    rd(2, IF_MAXV, "R12 in-flight at limit");
    checkVal("R6 no request at limit", int'(fetchReq), 0);
    rd(0, 2400 - IF_MAXV * WPI, "R6 count after fill");
    wr(1, 0);
    @(negedge clk); #1 fetchGnt = 1'b1;
    checkVal("R9 no request while disabled", int'(fetchReq), 0);
    for (int i = 0; i < IF_MAXV; i++) begin
      @(negedge clk); #1 doneIn = 1'b1;
      @(negedge clk); #1 doneIn = 1'b0;
    end
    rd(2, 0, "R9 drained to zero");
    rd(0, 2400 - IF_MAXV * WPI, "R9 count untouched while disabled");
    checkVal("R9 still no request", int'(fetchReq), 0);
    @(negedge clk); #1 fetchGnt = 1'b0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule